// File: doc/BRIEF.md
# Pseudowire Packet Disposition Classifier

This block chooses a destination for every received pseudowire packet: a payload engine, the CPU queue, or discard. Upstream logic has already parsed the headers and presents one descriptor per packet. The descriptor carries a header-type-valid flag, the pseudowire ID, the UDP payload protocol value with a UDP flag, the MPLS label count with an MPLS flag, and a flag for an in-band OAM control word. The block returns a destination code and a reason code naming the rule that decided the outcome.

Decisions come from an ordered chain of rules. Two lookups feed the chain. The first is a bundle table: a parallel compare over its entries, where each entry has a valid bit, a bundle ID, a debug-redirect bit and an in-band OAM monitor enable. The second is a table of out-of-band OAM IDs. Each exception class has its own global select bit that sends it either to the CPU or to discard. A bundle marked for debug is sent to the CPU, and all of that bundle's other settings are ignored.

A single write port loads the bundle entries, the OAM IDs and the global settings. Because writes are registered, a write that lands in the same cycle as a descriptor affects only later descriptors.

Top module: `pwdc_classifier`

## Requirements
- R1: For each cycle with `in_valid` high, `out_valid` is high in the next cycle and carries that descriptor's result; with no descriptor, `out_valid` is low in the next cycle. Descriptors may arrive back to back. Destination encoding: 00 payload engine, 01 CPU, 10 discard.
- R2: After reset, `out_valid` is low, every table entry is invalid, and all global settings are zero. A descriptor at that point therefore yields CPU with reason 6.
- R3: A descriptor whose header-type-valid flag is low, or whose ID matches neither a valid bundle entry nor a valid OAM ID, yields CPU with reason 6 (unknown).
- R4: A valid-header packet whose ID matches a valid OAM ID entry gives reason 1. Its destination is CPU when the OAM select bit is 0 and discard when it is 1. This rule outranks every bundle rule and works at every OAM index, 0 through 31.
- R5: A valid-header packet that matches a bundle with its debug bit set yields CPU with reason 2. The label count, the in-band flag and the UDP protocol have no effect on it.
- R6: A bundle packet (not debug) with the MPLS flag set and more than 2 labels gives reason 3. Its destination is CPU when the label select bit is 0 and discard when it is 1. Exactly 2 labels is not an exception.
- R7: A bundle packet with the in-band OAM flag set gives reason 4 only when that bundle's in-band monitor enable is set. Its destination follows the OAM select bit (0 CPU, 1 discard). When the enable is clear, the flag has no effect.
- R8: When verification is on, a UDP bundle packet whose protocol matches neither configured value gives reason 5. Its destination is CPU when the UDP select bit is 0 and discard when it is 1. With verification off, or with a matching value, the packet is not an exception.
- R9: A bundle packet that no higher rule catches yields payload engine (00) with reason 0.
- R10: When several valid bundle entries carry the same ID, the entry with the lowest index decides.
- R11: A configuration write in the same cycle as a descriptor does not affect that descriptor. It does affect the next one.
- R12: Write port layout. `cfg_sel` 0 writes bundle entry `cfg_addr`: bits 19:0 ID, bit 20 in-band enable, bit 21 debug, bit 22 valid. `cfg_sel` 1 writes OAM entry `cfg_addr`: bits 19:0 ID, bit 20 valid. `cfg_sel` 2 writes the globals: bits 15:0 protocol A, bits 31:16 protocol B, bit 32 verify enable, bit 33 UDP select, bit 34 OAM select, bit 35 label select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 bundle, 1 OAM ID, 2 globals |
| cfg_addr | input | 5 | Table index |
| cfg_wdata | input | 36 | Write data |
| in_valid | input | 1 | Descriptor strobe |
| in_hdr_ok | input | 1 | Recognised pseudowire header type |
| in_pw_id | input | 20 | Received pseudowire ID |
| in_is_udp | input | 1 | Packet is UDP-encapsulated |
| in_udp_proto | input | 16 | UDP payload protocol value |
| in_is_mpls | input | 1 | Packet is MPLS-encapsulated |
| in_lbl_cnt | input | 4 | Number of MPLS labels |
| in_oam_cw | input | 1 | In-band OAM control word seen |
| out_valid | output | 1 | Result strobe |
| out_dest | output | 2 | Destination code |
| out_reason | output | 3 | Rule that decided |

## Verification
Every result appears exactly one clock after its descriptor is sampled, with one register between the inputs and the outputs. The driver presents each descriptor at a falling edge and pushes its expected destination and reason into a queue. The monitor compares each result at the falling edge after the next rising edge, which is the cycle in which `out_valid` is due. A result that arrives with nothing pending counts as a timing failure, and so does an entry still waiting at the end. A write made together with a descriptor is checked against the settings that were in force before the write.

// File: rtl/pwdc_pkg.sv
package pwdc_pkg;
   typedef enum logic [1:0] {
      DST_PAYLOAD = 2'b00,
      DST_CPU     = 2'b01,
      DST_DROP    = 2'b10
   } dest_e;

   typedef enum logic [2:0] {
      RSN_FWD     = 3'd0,
      RSN_OAM_ID  = 3'd1,
      RSN_DEBUG   = 3'd2,
      RSN_LABELS  = 3'd3,
      RSN_INBAND  = 3'd4,
      RSN_UDP     = 3'd5,
      RSN_UNKNOWN = 3'd6
   } reason_e;

   localparam logic [1:0] SEL_BND = 2'd0;
   localparam logic [1:0] SEL_OAM = 2'd1;
   localparam logic [1:0] SEL_GLB = 2'd2;

   function automatic dest_e pick(input logic drop);
      return drop ? DST_DROP : DST_CPU;
   endfunction
endpackage

// File: rtl/pwdc_bundle_table.sv
module pwdc_bundle_table #(
   parameter int N    = 16,
   parameter int PW_W = 20,
   localparam int AW  = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic            wvalid,
   input  logic            wdebug,
   input  logic            winband,
   input  logic [PW_W-1:0] wbid,
   input  logic [PW_W-1:0] lk_id,
   output logic            hit,
   output logic            hit_debug,
   output logic            hit_inband
);
   logic [N-1:0]    v_q, dbg_q, ib_q;
   logic [PW_W-1:0] bid_q [N];
   logic [N-1:0]    eq, grant;
   logic [N:0]      below;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q   <= '0;
         dbg_q <= '0;
         ib_q  <= '0;
         for (int i = 0; i < N; i++) bid_q[i] <= '0;
      end else if (we) begin
         v_q[waddr]   <= wvalid;
         dbg_q[waddr] <= wdebug;
         ib_q[waddr]  <= winband;
         bid_q[waddr] <= wbid;
      end
   end

   assign below[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign eq[i]       = v_q[i] && (bid_q[i] == lk_id);
      assign grant[i]    = eq[i] && !below[i];
      assign below[i+1]  = below[i] | eq[i];
   end

   assign hit        = below[N];
   assign hit_debug  = |(grant & dbg_q);
   assign hit_inband = |(grant & ib_q);

   p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   p_hit_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ($countones(grant) == 1));
endmodule

// File: rtl/pwdc_oam_table.sv
module pwdc_oam_table #(
   parameter int N    = 32,
   parameter int PW_W = 20,
   localparam int AW  = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic            wvalid,
   input  logic [PW_W-1:0] wid,
   input  logic [PW_W-1:0] lk_id,
   output logic            hit
);
   logic [N-1:0]    v_q;
   logic [PW_W-1:0] id_q [N];
   logic [N-1:0]    eq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
         for (int i = 0; i < N; i++) id_q[i] <= '0;
      end else if (we) begin
         v_q[waddr]  <= wvalid;
         id_q[waddr] <= wid;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign eq[i] = v_q[i] && (id_q[i] == lk_id);
   end

   assign hit = |eq;

   p_reset_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (v_q == '0));
endmodule

// File: rtl/pwdc_rule_chain.sv
module pwdc_rule_chain
   import pwdc_pkg::*;
#(
   parameter int PROTO_W   = 16,
   parameter int LBL_W     = 4,
   parameter int LBL_LIMIT = 2
) (
   input  logic               hdr_ok,
   input  logic               oam_hit,
   input  logic               bnd_hit,
   input  logic               bnd_debug,
   input  logic               bnd_inband,
   input  logic               is_udp,
   input  logic [PROTO_W-1:0] udp_proto,
   input  logic               is_mpls,
   input  logic [LBL_W-1:0]   lbl_cnt,
   input  logic               oam_cw,
   input  logic               verify,
   input  logic [PROTO_W-1:0] proto_a,
   input  logic [PROTO_W-1:0] proto_b,
   input  logic               sel_udp,
   input  logic               sel_oam,
   input  logic               sel_lbl,
   output dest_e              dest,
   output reason_e            reason
);
   logic oam_ok, bnd_ok, lbl_bad, ib_seen, udp_bad;

   always_comb begin
      oam_ok  = hdr_ok && oam_hit;
      bnd_ok  = hdr_ok && bnd_hit;
      lbl_bad = is_mpls && (lbl_cnt > LBL_W'(LBL_LIMIT));
      ib_seen = bnd_inband && oam_cw;
      udp_bad = verify && is_udp && (udp_proto != proto_a) && (udp_proto != proto_b);
      dest    = DST_CPU;
      reason  = RSN_UNKNOWN;
      if (oam_ok) begin
         dest = pick(sel_oam);  reason = RSN_OAM_ID;
      end else if (bnd_ok) begin
         if (bnd_debug) begin
            dest = DST_CPU;     reason = RSN_DEBUG;
         end else if (lbl_bad) begin
            dest = pick(sel_lbl); reason = RSN_LABELS;
         end else if (ib_seen) begin
            dest = pick(sel_oam); reason = RSN_INBAND;
         end else if (udp_bad) begin
            dest = pick(sel_udp); reason = RSN_UDP;
         end else begin
            dest = DST_PAYLOAD; reason = RSN_FWD;
         end
      end
   end
endmodule

// File: rtl/pwdc_classifier.sv
module pwdc_classifier
   import pwdc_pkg::*;
#(
   parameter int PW_W      = 20,
   parameter int PROTO_W   = 16,
   parameter int LBL_W     = 4,
   parameter int N_BND     = 16,
   parameter int N_OAM     = 32,
   parameter int LBL_LIMIT = 2,
   localparam int BND_AW   = $clog2(N_BND),
   localparam int OAM_AW   = $clog2(N_OAM),
   localparam int ADDR_W   = (BND_AW > OAM_AW) ? BND_AW : OAM_AW,
   localparam int WD_A     = PW_W + 3,
   localparam int WD_B     = 2 * PROTO_W + 4,
   localparam int WD_W     = (WD_A > WD_B) ? WD_A : WD_B
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_sel,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [WD_W-1:0]    cfg_wdata,
   input  logic               in_valid,
   input  logic               in_hdr_ok,
   input  logic [PW_W-1:0]    in_pw_id,
   input  logic               in_is_udp,
   input  logic [PROTO_W-1:0] in_udp_proto,
   input  logic               in_is_mpls,
   input  logic [LBL_W-1:0]   in_lbl_cnt,
   input  logic               in_oam_cw,
   output logic               out_valid,
   output logic [1:0]         out_dest,
   output logic [2:0]         out_reason
);
   if (N_BND < 2 || N_BND > 64) begin : g_bad_bnd
      $error("N_BND must lie in 2..64");
   end
   if (N_OAM < 2 || N_OAM > 64) begin : g_bad_oam
      $error("N_OAM must lie in 2..64");
   end
   if (LBL_LIMIT >= (1 << LBL_W)) begin : g_bad_lbl
      $error("LBL_LIMIT does not fit LBL_W");
   end

   logic               bnd_we, oam_we, glb_we;
   logic               bnd_hit, bnd_dbg, bnd_ib, oam_hit;
   logic [PROTO_W-1:0] g_proto_a, g_proto_b;
   logic               g_verify, g_sel_udp, g_sel_oam, g_sel_lbl;
   dest_e              nx_dest;
   reason_e            nx_reason;

   assign bnd_we = cfg_we && (cfg_sel == SEL_BND) && (int'(cfg_addr) < N_BND);
   assign oam_we = cfg_we && (cfg_sel == SEL_OAM) && (int'(cfg_addr) < N_OAM);
   assign glb_we = cfg_we && (cfg_sel == SEL_GLB);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         g_proto_a <= '0;
         g_proto_b <= '0;
         g_verify  <= 1'b0;
         g_sel_udp <= 1'b0;
         g_sel_oam <= 1'b0;
         g_sel_lbl <= 1'b0;
      end else if (glb_we) begin
         g_proto_a <= cfg_wdata[PROTO_W-1:0];
         g_proto_b <= cfg_wdata[2*PROTO_W-1:PROTO_W];
         g_verify  <= cfg_wdata[2*PROTO_W];
         g_sel_udp <= cfg_wdata[2*PROTO_W+1];
         g_sel_oam <= cfg_wdata[2*PROTO_W+2];
         g_sel_lbl <= cfg_wdata[2*PROTO_W+3];
      end
   end

   pwdc_bundle_table #(.N(N_BND), .PW_W(PW_W)) u_bnd (
      .clk(clk), .rst_n(rst_n), .we(bnd_we),
      .waddr(cfg_addr[BND_AW-1:0]),
      .wvalid(cfg_wdata[PW_W+2]), .wdebug(cfg_wdata[PW_W+1]),
      .winband(cfg_wdata[PW_W]), .wbid(cfg_wdata[PW_W-1:0]),
      .lk_id(in_pw_id),
      .hit(bnd_hit), .hit_debug(bnd_dbg), .hit_inband(bnd_ib)
   );

   pwdc_oam_table #(.N(N_OAM), .PW_W(PW_W)) u_oam (
      .clk(clk), .rst_n(rst_n), .we(oam_we),
      .waddr(cfg_addr[OAM_AW-1:0]),
      .wvalid(cfg_wdata[PW_W]), .wid(cfg_wdata[PW_W-1:0]),
      .lk_id(in_pw_id), .hit(oam_hit)
   );

   pwdc_rule_chain #(.PROTO_W(PROTO_W), .LBL_W(LBL_W), .LBL_LIMIT(LBL_LIMIT)) u_rules (
      .hdr_ok(in_hdr_ok), .oam_hit(oam_hit), .bnd_hit(bnd_hit),
      .bnd_debug(bnd_dbg), .bnd_inband(bnd_ib),
      .is_udp(in_is_udp), .udp_proto(in_udp_proto),
      .is_mpls(in_is_mpls), .lbl_cnt(in_lbl_cnt), .oam_cw(in_oam_cw),
      .verify(g_verify), .proto_a(g_proto_a), .proto_b(g_proto_b),
      .sel_udp(g_sel_udp), .sel_oam(g_sel_oam), .sel_lbl(g_sel_lbl),
      .dest(nx_dest), .reason(nx_reason)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_dest   <= DST_PAYLOAD;
         out_reason <= RSN_FWD;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_dest   <= nx_dest;
            out_reason <= nx_reason;
         end
      end
   end

   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_dest_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_dest != 2'b11));
   p_nohdr_unknown_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_hdr_ok) |=> (out_reason == RSN_UNKNOWN && out_dest == DST_CPU));
   p_debug_cpu_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_reason == RSN_DEBUG) |-> (out_dest == DST_CPU));
   p_fwd_reason_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_dest == DST_PAYLOAD) |-> (out_reason == RSN_FWD));
   p_oam_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_hdr_ok && oam_hit) |=> (out_reason == RSN_OAM_ID));
endmodule

// File: tb/pwdc_classifier_test.sv
module pwdc_classifier_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [4:0]  cfg_addr = '0;
   logic [35:0] cfg_wdata = '0;
   logic        in_valid = 1'b0, in_hdr_ok = 1'b0, in_is_udp = 1'b0;
   logic [19:0] in_pw_id = '0;
   logic [15:0] in_udp_proto = '0;
   logic        in_is_mpls = 1'b0, in_oam_cw = 1'b0;
   logic [3:0]  in_lbl_cnt = '0;
   logic        out_valid;
   logic [1:0]  out_dest;
   logic [2:0]  out_reason;

   int checks = 0;
   int fails  = 0;
   logic [4:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pwdc_classifier uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
      .in_hdr_ok(in_hdr_ok), .in_pw_id(in_pw_id), .in_is_udp(in_is_udp),
      .in_udp_proto(in_udp_proto), .in_is_mpls(in_is_mpls),
      .in_lbl_cnt(in_lbl_cnt), .in_oam_cw(in_oam_cw),
      .out_valid(out_valid), .out_dest(out_dest), .out_reason(out_reason)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   function automatic logic [35:0] bnd_w(bit v, bit d, bit ib, logic [19:0] id);
      return {13'b0, v, d, ib, id};
   endfunction
   function automatic logic [35:0] oam_w(bit v, logic [19:0] id);
      return {15'b0, v, id};
   endfunction
   function automatic logic [35:0] glb_w(bit lbl, bit oam, bit udp, bit ver,
                                         logic [15:0] b, logic [15:0] a);
      return {lbl, oam, udp, ver, b, a};
   endfunction

   // monitor: results are due one clock after the descriptor edge
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R1 unexpected result", {out_dest, out_reason}, 0);
         end else begin
            logic [4:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({out_dest, out_reason} == e, t, {out_dest, out_reason}, e);
         end
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [4:0] a, input logic [35:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(input string tag, input bit hdr, input logic [19:0] id,
                       input bit udp, input logic [15:0] proto, input bit mpls,
                       input logic [3:0] lbl, input bit cw,
                       input logic [1:0] ed, input logic [2:0] er);
      in_valid = 1'b1; in_hdr_ok = hdr; in_pw_id = id; in_is_udp = udp;
      in_udp_proto = proto; in_is_mpls = mpls; in_lbl_cnt = lbl; in_oam_cw = cw;
      exp_q.push_back({ed, er});
      tag_q.push_back(tag);
      @(negedge clk);
      cfg_we = 1'b0;
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(out_valid == 1'b0, "R2 out_valid after reset", out_valid, 0);
      send("R2 empty tables", 1, 20'h0, 0, 0, 0, 0, 0, 2'b01, 3'd6);

      wr(2, 0, glb_w(1, 0, 0, 1, 16'h2222, 16'h1111));
      wr(0, 0, bnd_w(1, 0, 0, 20'h100));
      wr(0, 1, bnd_w(1, 1, 0, 20'h200));
      wr(0, 2, bnd_w(1, 0, 1, 20'h300));
      wr(0, 3, bnd_w(1, 0, 0, 20'h400));
      wr(0, 4, bnd_w(1, 1, 0, 20'h400));
      wr(0, 5, bnd_w(1, 1, 0, 20'h500));
      wr(1, 0, oam_w(1, 20'h900));
      wr(1, 31, oam_w(1, 20'hA00));
      wr(1, 7, oam_w(1, 20'h500));

      // back-to-back descriptors
      send("R9 plain bundle", 1, 20'h100, 0, 0, 0, 0, 0, 2'b00, 3'd0);
      send("R3 unknown id", 1, 20'h777, 0, 0, 0, 0, 0, 2'b01, 3'd6);
      send("R3 header invalid", 0, 20'h100, 0, 0, 0, 0, 0, 2'b01, 3'd6);
      send("R5 debug ignores rest", 1, 20'h200, 1, 16'h3333, 1, 4'd5, 1, 2'b01, 3'd2);
      send("R6 three labels", 1, 20'h100, 0, 0, 1, 4'd3, 0, 2'b10, 3'd3);
      send("R6 two labels", 1, 20'h100, 0, 0, 1, 4'd2, 0, 2'b00, 3'd0);
      send("R6 labels no mpls", 1, 20'h100, 0, 0, 0, 4'd9, 0, 2'b00, 3'd0);
      send("R7 inband enabled", 1, 20'h300, 0, 0, 0, 0, 1, 2'b01, 3'd4);
      send("R7 inband not enabled", 1, 20'h100, 0, 0, 0, 0, 1, 2'b00, 3'd0);
      send("R8 udp mismatch", 1, 20'h100, 1, 16'h3333, 0, 0, 0, 2'b01, 3'd5);
      send("R8 udp matches B", 1, 20'h100, 1, 16'h2222, 0, 0, 0, 2'b00, 3'd0);
      send("R10 lowest index wins", 1, 20'h400, 0, 0, 0, 0, 0, 2'b00, 3'd0);
      send("R4 oam over debug", 1, 20'h500, 0, 0, 0, 0, 0, 2'b01, 3'd1);
      send("R4 oam index 31", 1, 20'hA00, 0, 0, 0, 0, 0, 2'b01, 3'd1);
      send("R4 oam needs header", 0, 20'h900, 0, 0, 0, 0, 0, 2'b01, 3'd6);

      // write and descriptor in the same cycle
      cfg_we = 1'b1; cfg_sel = 2; cfg_addr = 0;
      cfg_wdata = glb_w(0, 1, 1, 1, 16'h2222, 16'h1111);
      send("R11 write same cycle", 1, 20'h100, 1, 16'h3333, 0, 0, 0, 2'b01, 3'd5);
      send("R11 write seen next", 1, 20'h100, 1, 16'h3333, 0, 0, 0, 2'b10, 3'd5);
      send("R4 oam drop", 1, 20'h900, 0, 0, 0, 0, 0, 2'b10, 3'd1);
      send("R7 inband drop", 1, 20'h300, 0, 0, 0, 0, 1, 2'b10, 3'd4);
      send("R6 labels to cpu", 1, 20'h100, 0, 0, 1, 4'd4, 0, 2'b01, 3'd3);

      wr(2, 0, glb_w(0, 1, 1, 0, 16'h2222, 16'h1111));
      send("R8 verify off", 1, 20'h100, 1, 16'h3333, 0, 0, 0, 2'b00, 3'd0);
      wr(0, 3, bnd_w(0, 0, 0, 20'h400));
      send("R12 entry cleared, R10 next index", 1, 20'h400, 0, 0, 0, 0, 0, 2'b01, 3'd2);
      wr(1, 7, oam_w(0, 20'h500));
      send("R12 oam cleared", 1, 20'h500, 0, 0, 0, 0, 0, 2'b01, 3'd2);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R1 missing results", exp_q.size(), 0);
      summary();
   end
endmodule